// File: doc/BRIEF.md
# Configuration Register Slave on a Two-Wire Serial Bus

This block lets a host on a two-wire serial bus (SMBus-style signalling) read and write a small bank of eight-bit configuration registers held inside the block. It samples the clock and data lines through two-flop synchronizers on a faster system clock. It detects start, repeated start and stop conditions, and it matches a fixed seven-bit device address. It then decodes a command byte. The open-drain data pin is modelled as a single drive-low enable, so the pad cell only pulls the line low when this output is high.

The top bit of the command byte selects the access type. With the top bit set, the access is indexed: one byte goes to or comes from the register named by the low command bits. With the top bit clear, the access is sequential over the whole bank. In that case a block write carries a byte count before its data, and a block read returns a byte count before the register contents, starting from the lowest register. Every register reloads its parameter default on reset, so a system that leaves the bus untouched still gets a working configuration. The current register contents are presented in parallel to the configuration logic that uses them.

Top module: `smb_cfg_slave`

## Requirements
- R1: The block acknowledges only the device address 7'h6A (address byte 8'hD4 for a write, 8'hD5 for a read). Any other address byte is left unacknowledged, and the rest of that transfer, up to the next start condition, is ignored.
- R2: A write with command bit 7 = 1 stores the next data byte into the register whose index is command bits [2:0]. The block acknowledges the address, the command and the data byte.
- R3: A read with command bit 7 = 1, sent after a repeated start with the read address, returns the register at index command bits [2:0], most significant bit first.
- R4: A write with command bit 7 = 0 takes the next byte as a count N. The data bytes that follow go to registers 0, 1, 2, … in order. Only the first N data bytes, and only those with an index below the bank size, are stored. Every byte is acknowledged.
- R5: A read with command bit 7 = 0 returns first the bank size (8) as a count, then registers 0 through 7 in order.
- R6: When the host answers a read byte with a not-acknowledge, the block stops driving the data line and keeps it released until the next start or stop.
- R7: A stop condition after any complete byte of a block write ends the transfer. The registers already written keep their new values, and the remaining registers keep their previous values.
- R8: Registers 4 to 7 are read-only (writable mask 8'h0F). A write aimed at them is acknowledged but leaves their contents unchanged.
- R9: After reset, the register outputs equal the defaults 8'h82, 8'h04, 8'h00, 8'h00, 8'hA5, 8'h00, 8'h31, 8'h00 for registers 0 to 7, and the data line is released.
- R10: The drive-low enable changes only in response to a falling edge of the serial clock, never while the clock is high. It is low whenever the block is idle.
- R11: A register write becomes visible on the register outputs exactly three system clock cycles after the serial clock falls at the end of the data byte's eighth bit. The register outputs change at no other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low reset, loads the register defaults |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_low | output | 1 | When high, the pad pulls the data line low |
| cfg_q | output | NREGS*8 | Register contents, register i in bits [8i+7:8i] |

## Verification
All results are timed from the serial clock edges that the bench drives, counted through the two synchronizer flops and the edge-detect flop. A register update is due three system cycles after the falling edge that ends a data byte. The bench keeps its own model of the register bank and applies each write to that model on exactly that cycle. It then compares the model with the register outputs on every falling system clock edge. The acknowledge bit and each read data bit are also due three cycles after a falling serial clock edge. The bench samples them a quarter of a serial period into the clock-high phase, well after they have settled and before the next falling edge can move them.

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
  parameter int NREGS = 8,
  parameter logic [6:0] DEV_ADDR = 7'h6A,
  parameter logic [NREGS*8-1:0] RST_VAL = 64'h00_31_00_A5_00_00_04_82,
  parameter logic [NREGS-1:0] WR_MASK = 8'h0F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_low,
  output logic [NREGS*8-1:0] cfg_q
);
  localparam int OFFW = (NREGS > 1) ? $clog2(NREGS) : 1;

  typedef enum logic [3:0] {
    S_IDLE = 4'd0, S_ADDR = 4'd1, S_AACK = 4'd2, S_CMD = 4'd3, S_CACK = 4'd4,
    S_WCNT = 4'd5, S_WACK = 4'd6, S_WDAT = 4'd7, S_TX = 4'd8, S_MACK = 4'd9
  } st_t;

  st_t st;
  logic [2:0] scl_sy, sda_sy;
  logic scl_s, scl_p, sda_s, sda_p;
  logic start_c, stop_c, rise_c, fall_c;
  logic [7:0] sh, tx, cnt, ptr;
  logic [3:0] bitcnt;
  logic rw, blk, mack;
  logic [OFFW-1:0] off;
  logic [7:0] rd_first, rd_next;
  logic [NREGS-1:0] wr_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
    end

  assign scl_s   = scl_sy[1];
  assign scl_p   = scl_sy[2];
  assign sda_s   = sda_sy[1];
  assign sda_p   = sda_sy[2];
  assign start_c = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_c  = scl_s & scl_p & ~sda_p & sda_s;
  assign rise_c  = scl_s & ~scl_p;
  assign fall_c  = ~scl_s & scl_p;

  always_comb begin
    rd_first = blk ? 8'(NREGS) : 8'hFF;
    rd_next  = 8'hFF;
    wr_hit   = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (!blk && off == OFFW'(i)) begin
        rd_first = cfg_q[i*8 +: 8];
        rd_next  = cfg_q[i*8 +: 8];
      end
      if (blk && ptr == 8'(i + 1)) rd_next = cfg_q[i*8 +: 8];
      wr_hit[i] = WR_MASK[i] &&
                  (blk ? (ptr == 8'(i) && ptr < cnt)
                       : (ptr == 8'd0 && off == OFFW'(i)));
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      sda_low <= 1'b0;
      cfg_q   <= RST_VAL;
      sh      <= '0;
      tx      <= '0;
      cnt     <= '0;
      ptr     <= '0;
      bitcnt  <= '0;
      rw      <= 1'b0;
      blk     <= 1'b0;
      mack    <= 1'b0;
      off     <= '0;
    end else if (start_c) begin
      st      <= S_ADDR;
      bitcnt  <= '0;
      sda_low <= 1'b0;
    end else if (stop_c) begin
      st      <= S_IDLE;
      sda_low <= 1'b0;
    end else begin
      case (st)
        S_ADDR, S_CMD, S_WCNT, S_WDAT: begin
          if (rise_c && bitcnt < 4'd8) begin
            sh     <= {sh[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end
          if (fall_c && bitcnt == 4'd8) begin
            case (st)
              S_ADDR:
                if (sh[7:1] == DEV_ADDR) begin
                  sda_low <= 1'b1;
                  rw      <= sh[0];
                  st      <= S_AACK;
                end else begin
                  st <= S_IDLE;
                end
              S_CMD: begin
                sda_low <= 1'b1;
                blk     <= ~sh[7];
                off     <= sh[OFFW-1:0];
                ptr     <= '0;
                st      <= S_CACK;
              end
              S_WCNT: begin
                sda_low <= 1'b1;
                cnt     <= sh;
                st      <= S_WACK;
              end
              default: begin
                sda_low <= 1'b1;
                for (int i = 0; i < NREGS; i++)
                  if (wr_hit[i]) cfg_q[i*8 +: 8] <= sh;
                if (ptr != 8'hFF) ptr <= ptr + 8'd1;
                st <= S_WACK;
              end
            endcase
          end
        end
        S_AACK:
          if (fall_c) begin
            bitcnt <= '0;
            if (rw) begin
              tx      <= rd_first;
              sda_low <= ~rd_first[7];
              ptr     <= 8'd1;
              st      <= S_TX;
            end else begin
              sda_low <= 1'b0;
              st      <= S_CMD;
            end
          end
        S_CACK:
          if (fall_c) begin
            sda_low <= 1'b0;
            bitcnt  <= '0;
            st      <= blk ? S_WCNT : S_WDAT;
          end
        S_WACK:
          if (fall_c) begin
            sda_low <= 1'b0;
            bitcnt  <= '0;
            st      <= S_WDAT;
          end
        S_TX:
          if (fall_c) begin
            if (bitcnt == 4'd7) begin
              sda_low <= 1'b0;
              st      <= S_MACK;
            end else begin
              tx      <= {tx[6:0], 1'b0};
              sda_low <= ~tx[6];
              bitcnt  <= bitcnt + 4'd1;
            end
          end
        S_MACK: begin
          if (rise_c) mack <= ~sda_s;
          if (fall_c) begin
            if (mack) begin
              tx      <= rd_next;
              sda_low <= ~rd_next[7];
              if (ptr != 8'hFF) ptr <= ptr + 8'd1;
              bitcnt  <= '0;
              st      <= S_TX;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: sda_low <= 1'b0;
      endcase
    end
endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk #(
  parameter int NREGS = 8,
  parameter logic [NREGS-1:0] WR_MASK = 8'h0F
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_s,
  input logic               scl_p,
  input logic [3:0]         st,
  input logic               sda_low,
  input logic [NREGS*8-1:0] cfg_q
);
  // R10
  drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_low) |-> $past(scl_p && !scl_s));

  // R10
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd0) |-> !sda_low);

  // R6
  released_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd0) |=> (!sda_low || st != 4'd0));

  // R11
  write_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> $past(scl_p && !scl_s));

  for (genvar g = 0; g < NREGS; g++) begin : g_ro
    if (!WR_MASK[g]) begin : g_chk
      // R8
      read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cfg_q[g*8 +: 8]));
    end
  end
endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NREGS(NREGS), .WR_MASK(WR_MASK)) chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_p(scl_p),
  .st(st), .sda_low(sda_low), .cfg_q(cfg_q));

// File: tb/smb_cfg_slave_test.sv
module smb_cfg_slave_test;
  localparam int Q = 8;
  localparam int H = 16;
  localparam logic [63:0] DEFAULTS = 64'h00_31_00_A5_00_00_04_82;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_low;
  logic [63:0] cfg_q;
  wire  sda_bus = m_sda & ~sda_low;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [63:0] model = DEFAULTS;
  bit pend = 0;
  int pend_at = 0;
  int pend_idx = 0;
  logic [7:0] pend_val = 0;
  bit running = 0;

  always #2.5 clk = ~clk;

  smb_cfg_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_low(sda_low), .cfg_q(cfg_q));

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (pend && cyc == pend_at) begin
      model[pend_idx*8 +: 8] = pend_val;
      pend = 0;
    end
  end

  // R11: registers follow the model cycle by cycle
  always @(negedge clk)
    if (running) begin
      checks++;
      if (cfg_q !== model) begin
        errors++;
        $display("FAIL R11 cycle %0d cfg_q act %h exp %h", cyc, cfg_q, model);
      end
    end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %h exp %h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    wt(Q); m_sda = 1'b0; wt(H); scl = 1'b0;
  endtask

  task automatic bus_rstart();
    wt(Q); m_sda = 1'b1; wt(Q); scl = 1'b1; wt(Q); m_sda = 1'b0; wt(Q); scl = 1'b0;
  endtask

  task automatic bus_stop();
    wt(Q); m_sda = 1'b0; wt(Q); scl = 1'b1; wt(Q); m_sda = 1'b1; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req,
                           input bit wr, input int idx);
    bit ack;
    for (int i = 7; i >= 0; i--) begin
      wt(Q); m_sda = b[i]; wt(Q); scl = 1'b1; wt(H); scl = 1'b0;
    end
    if (wr) begin
      pend_idx = idx; pend_val = b; pend_at = cyc + 3; pend = 1;
    end
    wt(Q); m_sda = 1'b1; wt(Q); scl = 1'b1; wt(Q);
    ack = ~sda_bus;
    chk(ack == exp_ack, req, int'(ack), int'(exp_ack));
    wt(Q); scl = 1'b0;
  endtask

  task automatic recv_byte(input bit ack, input logic [7:0] exp, input string req);
    logic [7:0] v = 8'h00;
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wt(H); scl = 1'b1; wt(Q); v = {v[6:0], sda_bus}; wt(Q); scl = 1'b0;
    end
    chk(v == exp, req, int'(v), int'(exp));
    wt(Q); m_sda = ~ack; wt(Q); scl = 1'b1; wt(H); scl = 1'b0;
    wt(Q); m_sda = 1'b1;
  endtask

  function automatic bit writable(input int idx);
    return idx < 4;
  endfunction

  initial begin
    repeat (5000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act %0d exp 0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wt(6);
    // R9: reset state
    chk(cfg_q == DEFAULTS, "R9 defaults", int'(cfg_q[31:0]), int'(DEFAULTS[31:0]));
    chk(cfg_q[63:32] == DEFAULTS[63:32], "R9 defaults hi", int'(cfg_q[63:32]), int'(DEFAULTS[63:32]));
    chk(sda_low == 1'b0, "R9 released", int'(sda_low), 0);
    rst_n = 1'b1;
    wt(4);
    running = 1;

    // R2: indexed write to register 0
    bus_start();
    send_byte(8'hD4, 1, "R1 addr ack", 0, 0);
    send_byte(8'h80, 1, "R2 cmd ack", 0, 0);
    send_byte(8'h5A, 1, "R2 data ack", writable(0), 0);
    bus_stop();
    chk(model[7:0] == 8'h5A, "R2 model", int'(model[7:0]), 'h5A);

    // R3: indexed read of register 0, R6 release after nack
    bus_start();
    send_byte(8'hD4, 1, "R1 addr ack", 0, 0);
    send_byte(8'h80, 1, "R3 cmd ack", 0, 0);
    bus_rstart();
    send_byte(8'hD5, 1, "R1 read addr ack", 0, 0);
    recv_byte(0, 8'h5A, "R3 read reg0");
    wt(H);
    chk(sda_low == 1'b0, "R6 released after nack", int'(sda_low), 0);
    bus_stop();
    chk(sda_low == 1'b0, "R10 idle released", int'(sda_low), 0);

    // R1: foreign address ignored
    bus_start();
    send_byte(8'hA0, 0, "R1 foreign nack", 0, 0);
    send_byte(8'h81, 0, "R1 ignored cmd", 0, 0);
    send_byte(8'h11, 0, "R1 ignored data", 0, 0);
    bus_stop();

    // R8: write to read-only register 6
    bus_start();
    send_byte(8'hD4, 1, "R1 addr ack", 0, 0);
    send_byte(8'h86, 1, "R8 cmd ack", 0, 0);
    send_byte(8'hEE, 1, "R8 data ack", writable(6), 6);
    bus_stop();
    chk(cfg_q[55:48] == 8'h31, "R8 ro kept", int'(cfg_q[55:48]), 'h31);

    // R4: block write count 3, fourth byte past count
    bus_start();
    send_byte(8'hD4, 1, "R1 addr ack", 0, 0);
    send_byte(8'h00, 1, "R4 cmd ack", 0, 0);
    send_byte(8'h03, 1, "R4 count ack", 0, 0);
    send_byte(8'h11, 1, "R4 d0 ack", writable(0), 0);
    send_byte(8'h22, 1, "R4 d1 ack", writable(1), 1);
    send_byte(8'h33, 1, "R4 d2 ack", writable(2), 2);
    send_byte(8'h44, 1, "R4 beyond count ack", 0, 3);
    bus_stop();
    chk(cfg_q[31:24] == 8'h00, "R4 reg3 untouched", int'(cfg_q[31:24]), 0);

    // R7: block write count 8 stopped after two bytes
    bus_start();
    send_byte(8'hD4, 1, "R1 addr ack", 0, 0);
    send_byte(8'h00, 1, "R7 cmd ack", 0, 0);
    send_byte(8'h08, 1, "R7 count ack", 0, 0);
    send_byte(8'h66, 1, "R7 d0 ack", writable(0), 0);
    send_byte(8'h77, 1, "R7 d1 ack", writable(1), 1);
    bus_stop();
    chk(cfg_q[23:16] == 8'h33, "R7 reg2 kept", int'(cfg_q[23:16]), 'h33);

    // R5: block read of whole bank
    bus_start();
    send_byte(8'hD4, 1, "R1 addr ack", 0, 0);
    send_byte(8'h00, 1, "R5 cmd ack", 0, 0);
    bus_rstart();
    send_byte(8'hD5, 1, "R1 read addr ack", 0, 0);
    recv_byte(1, 8'h08, "R5 count");
    for (int i = 0; i < 8; i++)
      recv_byte(i != 7, model[i*8 +: 8], "R5 data");
    wt(H);
    chk(sda_low == 1'b0, "R6 released after block nack", int'(sda_low), 0);
    bus_stop();

    // R3: indexed read of read-only register 6
    bus_start();
    send_byte(8'hD4, 1, "R1 addr ack", 0, 0);
    send_byte(8'h86, 1, "R3 cmd ack", 0, 0);
    bus_rstart();
    send_byte(8'hD5, 1, "R1 read addr ack", 0, 0);
    recv_byte(0, 8'h31, "R3 read reg6");
    bus_stop();

    wt(8);
    running = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule